// File: doc/BRIEF.md
# Upset-tolerant one-hot handshake controller

This block is a small control sequencer that steps through a four-phase handshake: idle, armed, running and finished. Its state register is one-hot, with one flip-flop per state. Every cycle, a dedicated checker confirms that the register holds a legal encoding. A radiation-induced bit flip can leave the register with no bit set or with several bits set. Normal transitions never reach such a pattern, and without detection the sequencer could stay stuck there.

When the checker sees an illegal pattern, it drives the error flag for that cycle. On the next clock edge the register is forced to a recovery target, with no outside help. The parameter `RECOVER_TO_ERROR` selects the target:

- When it is 0, the target is the idle state.
- When it is 1, the target is a separate fault state. This state holds until software-side logic asserts `err_clear`.

A saturating counter records how many cycles were flagged. A test-only injection port XORs a mask into the state register, so that upsets can be produced on demand.

The state encoding is bit 0 idle, bit 1 armed, bit 2 running, bit 3 finished and bit 4 fault. All inputs are plain control levels sampled on the rising clock edge. There is no data stream and so no back-pressure.

Top module: `onehot_guard_fsm`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes idle (`cur_state` = 5'b00001) and `err_count` becomes 0. After reset, `state_valid` is 1 and `err_flag` is 0.
- R2: In idle, `start` moves the state to armed (5'b00010) at the next edge; otherwise idle holds.
- R3: In armed, `go` moves the state to running (5'b00100); otherwise armed holds.
- R4: In running, `finish` moves the state to finished (5'b01000); otherwise running holds.
- R5: Finished moves to idle at the next edge, whatever the inputs are.
- R6: `state_valid` is 1 exactly when `cur_state` has one bit set and that bit is a legal state. The fault bit (bit 4) is legal only when `RECOVER_TO_ERROR` is 1. The all-zero pattern and any pattern with two or more bits set are illegal. `err_flag` is the inverse of `state_valid`.
- R7: When `inj_valid` is high at an edge (and `rst` is low), the register loads `cur_state ^ inj_mask` in place of its normal next value.
- R8: With `RECOVER_TO_ERROR` = 0, an illegal state is replaced by idle at the next edge.
- R9: With `RECOVER_TO_ERROR` = 1, an illegal state is replaced by the fault state (5'b10000) at the next edge. The fault state ignores `start`, `go` and `finish`, holds while `err_clear` is low, and moves to idle at the first edge where `err_clear` is high.
- R10: `err_count` increments by one at each edge where `err_flag` is high, and it saturates at its maximum of 255.
- R11: After a single-cycle injection, `state_valid` is 1 no later than two edges after the injecting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Leave idle for armed |
| go | input | 1 | Leave armed for running |
| finish | input | 1 | Leave running for finished |
| err_clear | input | 1 | Release the fault state to idle |
| inj_valid | input | 1 | Test-only: apply the injection mask this edge |
| inj_mask | input | 5 | Test-only: bits to flip in the state register |
| cur_state | output | 5 | One-hot state register |
| state_valid | output | 1 | Current encoding is legal |
| err_flag | output | 1 | Current encoding is illegal (detection) |
| err_count | output | 8 | Saturating count of detections |

## Verification
On every cycle, the assertions check several properties:

- A valid state has a single bit set.
- Any flagged state goes to the configured target on the next edge.
- The finished state always returns to idle.
- The fault state holds while `err_clear` is low.
- The counter either steps by one or stays at saturation.
- The machine is legal again two edges after an injection.

Some behaviours can only be shown by the bench scenarios, which run both recovery variants side by side against a behavioural model. These scenarios show which illegal patterns are produced from which states, including the zero, single-extra-bit, multi-bit and fault-bit patterns. They also show that an injection which lands on another legal state is accepted without a flag, and that the counter actually reaches 255 and stops there.

// File: rtl/ohg_pkg.sv
package ohg_pkg;
  localparam int STW      = 5;
  localparam int IX_IDLE  = 0;
  localparam int IX_ARM   = 1;
  localparam int IX_RUN   = 2;
  localparam int IX_DONE  = 3;
  localparam int IX_FAULT = 4;

  typedef logic [STW-1:0] st_t;

  localparam st_t ST_IDLE  = st_t'(1) << IX_IDLE;
  localparam st_t ST_ARM   = st_t'(1) << IX_ARM;
  localparam st_t ST_RUN   = st_t'(1) << IX_RUN;
  localparam st_t ST_DONE  = st_t'(1) << IX_DONE;
  localparam st_t ST_FAULT = st_t'(1) << IX_FAULT;
endpackage

// File: rtl/ohg_legal_check.sv
module ohg_legal_check
  import ohg_pkg::*;
#(
  parameter bit RECOVER_TO_ERROR = 1'b1
) (
  input  st_t  st,
  output logic legal
);
  logic any_set;
  logic multi_set;
  logic bad_bit;

  always_comb begin
    logic seen;
    seen      = 1'b0;
    multi_set = 1'b0;
    for (int i = 0; i < STW; i++) begin
      multi_set = multi_set | (seen & st[i]);
      seen      = seen | st[i];
    end
    any_set = seen;
  end

  generate
    if (RECOVER_TO_ERROR) begin : g_fault_ok
      assign bad_bit = 1'b0;
    end else begin : g_fault_bad
      assign bad_bit = st[IX_FAULT];
    end
  endgenerate

  assign legal = any_set & ~multi_set & ~bad_bit;
endmodule

// File: rtl/ohg_next_state.sv
module ohg_next_state
  import ohg_pkg::*;
#(
  parameter bit RECOVER_TO_ERROR = 1'b1
) (
  input  st_t  st,
  input  logic legal,
  input  logic start,
  input  logic go,
  input  logic finish,
  input  logic err_clear,
  input  logic inj_valid,
  input  st_t  inj_mask,
  output st_t  nxt
);
  localparam st_t REC_TARGET = RECOVER_TO_ERROR ? ST_FAULT : ST_IDLE;

  always_comb begin
    nxt = st;
    if (inj_valid) begin
      nxt = st ^ inj_mask;
    end else if (!legal) begin
      nxt = REC_TARGET;
    end else if (st[IX_IDLE]) begin
      if (start) nxt = ST_ARM;
    end else if (st[IX_ARM]) begin
      if (go) nxt = ST_RUN;
    end else if (st[IX_RUN]) begin
      if (finish) nxt = ST_DONE;
    end else if (st[IX_DONE]) begin
      nxt = ST_IDLE;
    end else begin
      if (err_clear) nxt = ST_IDLE;
    end
  end
endmodule

// File: rtl/ohg_sat_counter.sv
module ohg_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (bump && count != CNT_MAX) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/onehot_guard_fsm.sv
module onehot_guard_fsm
  import ohg_pkg::*;
#(
  parameter bit RECOVER_TO_ERROR = 1'b1,
  parameter int CNT_W            = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             go,
  input  logic             finish,
  input  logic             err_clear,
  input  logic             inj_valid,
  input  logic [STW-1:0]   inj_mask,
  output logic [STW-1:0]   cur_state,
  output logic             state_valid,
  output logic             err_flag,
  output logic [CNT_W-1:0] err_count
);
  st_t  st_q;
  st_t  st_d;
  logic legal;

  ohg_legal_check #(.RECOVER_TO_ERROR(RECOVER_TO_ERROR)) u_check (
    .st    (st_q),
    .legal (legal)
  );

  ohg_next_state #(.RECOVER_TO_ERROR(RECOVER_TO_ERROR)) u_next (
    .st        (st_q),
    .legal     (legal),
    .start     (start),
    .go        (go),
    .finish    (finish),
    .err_clear (err_clear),
    .inj_valid (inj_valid),
    .inj_mask  (inj_mask),
    .nxt       (st_d)
  );

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  ohg_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .bump  (~legal),
    .count (err_count)
  );

  assign cur_state   = st_q;
  assign state_valid = legal;
  assign err_flag    = ~legal;
endmodule

// File: rtl/onehot_guard_fsm_sva.sv
module onehot_guard_fsm_sva
  import ohg_pkg::*;
#(
  parameter bit RECOVER_TO_ERROR = 1'b1,
  parameter int CNT_W            = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             err_clear,
  input logic             inj_valid,
  input logic [STW-1:0]   cur_state,
  input logic             state_valid,
  input logic             err_flag,
  input logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam st_t REC_TARGET = RECOVER_TO_ERROR ? ST_FAULT : ST_IDLE;

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cur_state == ST_IDLE && err_count == '0)); // R1

  AST_DONE_RETURNS: assert property (@(posedge clk) disable iff (rst)
    (cur_state == ST_DONE && !inj_valid) |=> cur_state == ST_IDLE); // R5

  AST_VALID_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    state_valid |-> $countones(cur_state) == 1); // R6

  AST_RECOVER_TARGET: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !inj_valid) |=> cur_state == REC_TARGET); // R8

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (RECOVER_TO_ERROR && cur_state == ST_FAULT && !err_clear && !inj_valid)
      |=> cur_state == ST_FAULT); // R9

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (err_flag && err_count != CNT_MAX) |=> err_count == $past(err_count) + 1'b1); // R10

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (err_count == CNT_MAX) |=> err_count == CNT_MAX); // R10

  AST_LEGAL_IN_TWO: assert property (@(posedge clk) disable iff (rst)
    (inj_valid ##1 !inj_valid) |=> state_valid); // R11
endmodule

bind onehot_guard_fsm onehot_guard_fsm_sva #(
  .RECOVER_TO_ERROR(RECOVER_TO_ERROR),
  .CNT_W(CNT_W)
) u_sva (
  .clk         (clk),
  .rst         (rst),
  .err_clear   (err_clear),
  .inj_valid   (inj_valid),
  .cur_state   (cur_state),
  .state_valid (state_valid),
  .err_flag    (err_flag),
  .err_count   (err_count)
);

// File: tb/onehot_guard_fsm_bench.sv
module onehot_guard_fsm_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, go = 1'b0, finish = 1'b0, err_clear = 1'b0, inj_valid = 1'b0;
  logic [4:0] inj_mask = '0;

  logic [4:0] st_e, st_i;
  logic       val_e, val_i, flg_e, flg_i;
  logic [7:0] cnt_e, cnt_i;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // fault-state variant
  onehot_guard_fsm #(.RECOVER_TO_ERROR(1'b1)) u_onehot_guard_fsm (
    .clk(clk), .rst(rst), .start(start), .go(go), .finish(finish),
    .err_clear(err_clear), .inj_valid(inj_valid), .inj_mask(inj_mask),
    .cur_state(st_e), .state_valid(val_e), .err_flag(flg_e), .err_count(cnt_e));

  // idle-recovery variant
  onehot_guard_fsm #(.RECOVER_TO_ERROR(1'b0)) u_onehot_guard_fsm_idle (
    .clk(clk), .rst(rst), .start(start), .go(go), .finish(finish),
    .err_clear(err_clear), .inj_valid(inj_valid), .inj_mask(inj_mask),
    .cur_state(st_i), .state_valid(val_i), .err_flag(flg_i), .err_count(cnt_i));

  // behavioural reference: index 0 = fault variant, 1 = idle variant
  int m_st  [2];
  int m_cnt [2];

  function automatic bit m_legal(int s, int mode_fault);
    int ones = 0;
    for (int b = 0; b < 5; b++) if (s[b]) ones++;
    if (ones != 1) return 1'b0;
    if (s == 16 && mode_fault == 0) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int m_next(int s, int mode_fault);
    if (inj_valid) return s ^ int'(inj_mask);
    if (!m_legal(s, mode_fault)) return mode_fault ? 16 : 1;
    case (s)
      1:  return start  ? 2 : 1;
      2:  return go     ? 4 : 2;
      4:  return finish ? 8 : 4;
      8:  return 1;
      default: return err_clear ? 1 : 16;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      int mf;
      mf = (k == 0) ? 1 : 0;
      if (rst) begin
        m_st[k]  = 1;
        m_cnt[k] = 0;
      end else begin
        if (!m_legal(m_st[k], mf) && m_cnt[k] < 255) m_cnt[k] = m_cnt[k] + 1;
        m_st[k] = m_next(m_st[k], mf);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  bit cmp_on = 1'b0;
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R2 R3 R4 R7 fault-variant state", int'(st_e), m_st[0]);
      check("R6 fault-variant state_valid", int'(val_e), int'(m_legal(m_st[0], 1)));
      check("R6 fault-variant err_flag", int'(flg_e), int'(!m_legal(m_st[0], 1)));
      check("R10 fault-variant err_count", int'(cnt_e), m_cnt[0]);
      check("R8 idle-variant state", int'(st_i), m_st[1]);
      check("R6 idle-variant state_valid", int'(val_i), int'(m_legal(m_st[1], 0)));
      check("R6 idle-variant err_flag", int'(flg_i), int'(!m_legal(m_st[1], 0)));
      check("R10 idle-variant err_count", int'(cnt_i), m_cnt[1]);
    end
  end

  task automatic drive(bit s, bit g, bit f, bit c, bit iv, logic [4:0] m);
    @(negedge clk);
    start = s; go = g; finish = f; err_clear = c; inj_valid = iv; inj_mask = m;
  endtask

  task automatic idle_cycle();
    drive(0, 0, 0, 0, 0, 5'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", MAX_CYCLES);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset state", int'(st_e), 1);
    check("R1 reset count", int'(cnt_e), 0);
    check("R1 reset valid", int'(val_e), 1);
    check("R1 reset flag", int'(flg_e), 0);
    cmp_on = 1'b1;

    // R2..R5 walk, with holds and stray inputs
    drive(0, 1, 1, 1, 0, 5'b0); idle_cycle();
    check("R2 idle holds", int'(st_e), 1);
    drive(1, 0, 0, 0, 0, 5'b0); idle_cycle();
    check("R2 idle to arm", int'(st_e), 2);
    drive(1, 0, 1, 1, 0, 5'b0); idle_cycle();
    check("R3 arm holds", int'(st_e), 2);
    drive(0, 1, 0, 0, 0, 5'b0); idle_cycle();
    check("R3 arm to run", int'(st_e), 4);
    drive(1, 1, 0, 1, 0, 5'b0); idle_cycle();
    check("R4 run holds", int'(st_i), 4);
    drive(0, 0, 1, 0, 0, 5'b0);
    drive(1, 1, 1, 1, 0, 5'b0);
    check("R4 run to done", int'(st_e), 8);
    idle_cycle();
    check("R5 done to idle", int'(st_e), 1);

    // R7/R6 injection to zero pattern
    drive(0, 0, 0, 0, 1, 5'b00001); idle_cycle();
    check("R7 zero pattern", int'(st_e), 0);
    check("R6 zero flagged", int'(flg_e), 1);
    idle_cycle();
    check("R9 zero to fault", int'(st_e), 16);
    check("R8 zero to idle", int'(st_i), 1);
    drive(1, 1, 1, 0, 0, 5'b0); idle_cycle();
    check("R9 fault holds", int'(st_e), 16);
    drive(0, 0, 0, 1, 0, 5'b0); idle_cycle();
    check("R9 fault cleared", int'(st_e), 1);

    // multi-bit upset from run
    drive(1, 0, 0, 0, 0, 5'b0); drive(0, 1, 0, 0, 0, 5'b0);
    drive(0, 0, 0, 0, 1, 5'b01010); idle_cycle();
    check("R7 multi pattern", int'(st_i), 5'b01110);
    check("R6 multi invalid", int'(val_i), 0);
    idle_cycle();
    check("R11 legal in two", int'(val_e), 1);
    drive(0, 0, 0, 1, 0, 5'b0);

    // fault bit flipped in from idle: legal in fault variant, illegal in idle variant
    drive(0, 0, 0, 0, 1, 5'b10001); idle_cycle();
    check("R6 fault bit legal when enabled", int'(val_e), 1);
    check("R6 fault bit illegal when disabled", int'(val_i), 0);
    idle_cycle();
    check("R8 fault bit to idle", int'(st_i), 1);
    drive(0, 0, 0, 1, 0, 5'b0);

    // injection onto another legal state: no flag
    drive(0, 0, 0, 0, 1, 5'b00011); idle_cycle();
    check("R7 legal jump to arm", int'(st_e), 2);
    check("R6 legal jump no flag", int'(flg_e), 0);
    drive(0, 1, 0, 0, 0, 5'b0); drive(0, 0, 1, 0, 0, 5'b0); idle_cycle();

    // R10 saturation
    for (int n = 0; n < 260; n++) begin
      drive(0, 0, 0, 0, 1, 5'b00010);
      idle_cycle();
      drive(0, 0, 0, 1, 0, 5'b0);
    end
    idle_cycle();
    check("R10 saturated fault variant", int'(cnt_e), 255);
    check("R10 saturated idle variant", int'(cnt_i), 255);

    // R1 reset mid-fault
    drive(0, 0, 0, 0, 1, 5'b00110);
    rst = 1'b1;
    idle_cycle();
    rst = 1'b0;
    idle_cycle();
    check("R1 reset clears count", int'(cnt_e), 0);
    check("R1 reset state again", int'(st_e), 1);

    repeat (3) idle_cycle();
    finish_run();
  end
endmodule